// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps the time of day and the calendar as packed BCD counters. A prescaler divides a slow clock enable down to a 128 Hz tick. The tick drives a 7-bit sub-second counter, and the rollover of that counter advances seconds. Seconds then cascade into minutes, hours, weekday, day of month, month, year and, optionally, a BCD century byte.

Software uses a byte-wide register port. It stops the counter, loads every time field, then restarts it. Reads return the live count. A carry flag records that seconds advanced. Software clears the flag before a multi-register read and checks it afterwards, so it can detect a read that straddled a rollover and retry. The flag can also raise an interrupt.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register offsets are: 0 sub-second (bit 7 reads 0), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year (low two BCD digits), 8 century, 14 control A, 15 control B. Unlisted offsets read 0. After reset the fields read as follows:
  - sub-second, seconds, minutes, hours and weekday read 0;
  - day and month read 0x01;
  - year reads 0x00 and century reads 0x20;
  - both control registers read 0x00.
- R2: While counting is halted, a write to offsets 1 to 8 loads the byte as written, and it reads back unchanged.
- R3: While counting runs, writes to offsets 1 to 8 are ignored.
- R4: The sub-second counter is advanced by one tick every PRESCALE_DIV enables, and its bit 6 is set once 64 ticks have passed. While control B bit 1 (prescaler reset) is 1, the prescaler and the sub-second counter are held at 0.
- R5: When the sub-second counter wraps from 127 to 0, seconds advance. Seconds wrap 0x59 to 0x00 and carry into minutes. Minutes wrap 0x59 to 0x00 and carry into hours. Hours wrap 0x23 to 0x00 and carry into the day.
- R6: The weekday advances with each day carry and wraps from 0x06 to 0x00.
- R7: The day wraps back to 0x01 after the month's last day. That last day is:
  - 0x30 for months 0x04, 0x06, 0x09 and 0x11;
  - 0x29 for month 0x02 when the BCD year is a multiple of 4, otherwise 0x28;
  - 0x31 for all other months.
- R8: Month wraps from 0x12 to 0x01 and advances the year. The year wraps from 0x99 to 0x00 and advances the century, when FOUR_DIGIT_YEAR is 1.
- R9: Control A bit 7 (carry flag) sets on every seconds advance. Writing 0 to that bit clears it, and writing 1 to it has no effect.
- R10: carry_irq_o is high exactly when the carry flag and control A bit 4 (carry interrupt enable) are both 1.
- R11: Counting runs only when control B bit 3 (enable) is 1, bit 0 (start) is 1 and bit 1 is 0. Otherwise every counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Slow clock enable feeding the prescaler |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| carry_irq_o | output | 1 | Carry interrupt request |

## Verification
The bench loads times just before a midnight rollover and lets one second pass. A full ripple must land on the correct next date in each of these cases:
- a 28-day February;
- a leap February;
- a 30-day month;
- the end of a year and century.

A design with a broken carry chain or a wrong month-length table would stop on a day such as 0x29 or 0x31, or would leave the century unchanged. The bench also writes to the counters while they run, to catch loads that are not gated. It writes 1 to the carry flag, to catch a flag that is set by software rather than only cleared. It tries starting with the enable off, to catch a run condition that ignores one of its three control bits.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W = 4;
  localparam int SUB_W  = 7;   // 128 ticks per second
  localparam logic [ADDR_W-1:0] A_SUB  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'd3;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'd4;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MON  = 4'd6;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'd7;
  localparam logic [ADDR_W-1:0] A_CENT = 4'd8;
  localparam logic [ADDR_W-1:0] A_CTLA = 4'd14;
  localparam logic [ADDR_W-1:0] A_CTLB = 4'd15;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 straight from BCD digits
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && en_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R4
  presc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o);
endmodule

// File: rtl/rtc_bcd_cnt.sv
module rtc_bcd_cnt #(
  parameter logic [7:0] RESET_VAL = 8'h00,
  parameter logic [7:0] MIN_VAL   = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic [7:0] max_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  import rtc_cal_pkg::*;

  logic [7:0] val_q;

  assign val_o  = val_q;
  assign wrap_o = inc_i && (val_q == max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RESET_VAL;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= (val_q == max_i) ? MIN_VAL : bcd_inc(val_q);
  end

  // R5
  wrap_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && val_q == max_i) |=> (val_q == MIN_VAL));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(val_q));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int PRESCALE_DIV    = 256,
  parameter bit FOUR_DIGIT_YEAR = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_en_i,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       carry_irq_o
);
  import rtc_cal_pkg::*;

  localparam int NF = 8;  // sec, min, hour, wday, day, mon, year, cent
  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  logic cf_q, cie_q, en_q, prst_q, start_q;
  logic running, tick;
  logic [SUB_W-1:0] sub_q;
  logic sec_inc;

  logic [7:0] fval  [NF];
  logic [7:0] fmax  [NF];
  logic [NF-1:0] finc, fwrap, fload;

  assign running = en_q && start_q && !prst_q;

  rtc_prescaler #(.DIV(PRESCALE_DIV)) i_presc (
    .clk_i, .rst_ni, .en_i(tick_en_i), .run_i(running), .clr_i(prst_q), .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sub_q <= '0;
    else if (prst_q) sub_q <= '0;
    else if (tick)   sub_q <= sub_q + 1'b1;
  end

  assign sec_inc = tick && (sub_q == SUB_LAST);

  // carry cascade
  assign finc[0] = sec_inc;
  assign finc[1] = fwrap[0];
  assign finc[2] = fwrap[1];
  assign finc[3] = fwrap[2];
  assign finc[4] = fwrap[2];
  assign finc[5] = fwrap[4];
  assign finc[6] = fwrap[5];
  assign finc[7] = fwrap[6];

  assign fmax[0] = 8'h59;
  assign fmax[1] = 8'h59;
  assign fmax[2] = 8'h23;
  assign fmax[3] = 8'h06;
  assign fmax[4] = last_day(fval[5], bcd_leap(fval[6]));
  assign fmax[5] = 8'h12;
  assign fmax[6] = 8'h99;
  assign fmax[7] = 8'h99;

  for (genvar i = 0; i < NF; i++) begin : g_load
    assign fload[i] = we_i && !running && (addr_i == A_SEC + ADDR_W'(i));
  end

  rtc_bcd_cnt #(.RESET_VAL(8'h00), .MIN_VAL(8'h00)) i_sec (
    .clk_i, .rst_ni, .inc_i(finc[0]), .load_i(fload[0]), .load_val_i(wdata_i),
    .max_i(fmax[0]), .val_o(fval[0]), .wrap_o(fwrap[0]));
  rtc_bcd_cnt #(.RESET_VAL(8'h00), .MIN_VAL(8'h00)) i_min (
    .clk_i, .rst_ni, .inc_i(finc[1]), .load_i(fload[1]), .load_val_i(wdata_i),
    .max_i(fmax[1]), .val_o(fval[1]), .wrap_o(fwrap[1]));
  rtc_bcd_cnt #(.RESET_VAL(8'h00), .MIN_VAL(8'h00)) i_hour (
    .clk_i, .rst_ni, .inc_i(finc[2]), .load_i(fload[2]), .load_val_i(wdata_i),
    .max_i(fmax[2]), .val_o(fval[2]), .wrap_o(fwrap[2]));
  rtc_bcd_cnt #(.RESET_VAL(8'h00), .MIN_VAL(8'h00)) i_wday (
    .clk_i, .rst_ni, .inc_i(finc[3]), .load_i(fload[3]), .load_val_i(wdata_i),
    .max_i(fmax[3]), .val_o(fval[3]), .wrap_o(fwrap[3]));
  rtc_bcd_cnt #(.RESET_VAL(8'h01), .MIN_VAL(8'h01)) i_day (
    .clk_i, .rst_ni, .inc_i(finc[4]), .load_i(fload[4]), .load_val_i(wdata_i),
    .max_i(fmax[4]), .val_o(fval[4]), .wrap_o(fwrap[4]));
  rtc_bcd_cnt #(.RESET_VAL(8'h01), .MIN_VAL(8'h01)) i_mon (
    .clk_i, .rst_ni, .inc_i(finc[5]), .load_i(fload[5]), .load_val_i(wdata_i),
    .max_i(fmax[5]), .val_o(fval[5]), .wrap_o(fwrap[5]));
  rtc_bcd_cnt #(.RESET_VAL(8'h00), .MIN_VAL(8'h00)) i_year (
    .clk_i, .rst_ni, .inc_i(finc[6]), .load_i(fload[6]), .load_val_i(wdata_i),
    .max_i(fmax[6]), .val_o(fval[6]), .wrap_o(fwrap[6]));

  if (FOUR_DIGIT_YEAR) begin : g_cent
    rtc_bcd_cnt #(.RESET_VAL(8'h20), .MIN_VAL(8'h00)) i_cent (
      .clk_i, .rst_ni, .inc_i(finc[7]), .load_i(fload[7]), .load_val_i(wdata_i),
      .max_i(fmax[7]), .val_o(fval[7]), .wrap_o(fwrap[7]));
  end else begin : g_no_cent
    assign fval[7]  = 8'h00;
    assign fwrap[7] = 1'b0;
  end

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_q <= 1'b0; cie_q <= 1'b0;
      en_q <= 1'b0; prst_q <= 1'b0; start_q <= 1'b0;
    end else begin
      if (sec_inc)                                cf_q <= 1'b1;
      else if (we_i && addr_i == A_CTLA && !wdata_i[7]) cf_q <= 1'b0;
      if (we_i && addr_i == A_CTLA) cie_q <= wdata_i[4];
      if (we_i && addr_i == A_CTLB) begin
        en_q    <= wdata_i[3];
        prst_q  <= wdata_i[1];
        start_q <= wdata_i[0];
      end
    end
  end

  assign carry_irq_o = cf_q && cie_q;

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == A_SUB)                          rdata_o = {1'b0, sub_q};
    else if (addr_i >= A_SEC && addr_i <= A_CENT) rdata_o = fval[addr_i - A_SEC];
    else if (addr_i == A_CTLA)                    rdata_o = {cf_q, 2'b00, cie_q, 4'h0};
    else if (addr_i == A_CTLB)                    rdata_o = {4'h0, en_q, 1'b0, prst_q, start_q};
  end

  // R3
  run_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && running && addr_i == A_MIN && !finc[1]) |=> (fval[1] == $past(fval[1])));
  // R9
  carry_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_inc |=> cf_q);
  // R11
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !prst_q) |=> $stable(sub_q));
  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cie_q |-> !carry_irq_o);
  // R6
  wday_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finc[3] && fval[3] == 8'h06) |=> (fval[3] == 8'h00));
endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
  logic clk = 1'b0, rst_ni = 1'b0, tick_en = 1'b1, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_calendar_core #(.PRESCALE_DIV(2), .FOUR_DIGIT_YEAR(1'b1)) i_rtc_calendar_core (
    .clk_i(clk), .rst_ni(rst_ni), .tick_en_i(tick_en), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .carry_irq_o(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic load_time(input logic [7:0] cent, yr, mon, day, wd, hr, mn, sc);
    wr(4'd15, 8'h0A);
    wr(4'd1, sc); wr(4'd2, mn); wr(4'd3, hr); wr(4'd4, wd);
    wr(4'd5, day); wr(4'd6, mon); wr(4'd7, yr); wr(4'd8, cent);
  endtask

  task automatic run_for(input int d);
    wr(4'd15, 8'h09);
    repeat (d) @(negedge clk);
    wr(4'd15, 8'h08);
  endtask

  task automatic t_reset;
    expect_reg("R1 sub", 4'd0, 8'h00);  expect_reg("R1 sec", 4'd1, 8'h00);
    expect_reg("R1 min", 4'd2, 8'h00);  expect_reg("R1 hour", 4'd3, 8'h00);
    expect_reg("R1 wday", 4'd4, 8'h00); expect_reg("R1 day", 4'd5, 8'h01);
    expect_reg("R1 mon", 4'd6, 8'h01);  expect_reg("R1 year", 4'd7, 8'h00);
    expect_reg("R1 cent", 4'd8, 8'h20); expect_reg("R1 ctla", 4'd14, 8'h00);
    expect_reg("R1 ctlb", 4'd15, 8'h00); expect_reg("R1 unmapped", 4'd10, 8'h00);
    chk("R10 irq reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_load;
    load_time(8'h19, 8'h87, 8'h07, 8'h14, 8'h02, 8'h13, 8'h45, 8'h27);
    expect_reg("R2 sec", 4'd1, 8'h27);  expect_reg("R2 min", 4'd2, 8'h45);
    expect_reg("R2 hour", 4'd3, 8'h13); expect_reg("R2 wday", 4'd4, 8'h02);
    expect_reg("R2 day", 4'd5, 8'h14);  expect_reg("R2 mon", 4'd6, 8'h07);
    expect_reg("R2 year", 4'd7, 8'h87); expect_reg("R2 cent", 4'd8, 8'h19);
  endtask

  task automatic t_run_write;
    load_time(8'h20, 8'h10, 8'h05, 8'h15, 8'h03, 8'h10, 8'h20, 8'h30);
    wr(4'd15, 8'h09);
    wr(4'd1, 8'h55); wr(4'd2, 8'h44); wr(4'd5, 8'h02);
    wr(4'd15, 8'h08);
    expect_reg("R3 sec", 4'd1, 8'h30);
    expect_reg("R3 min", 4'd2, 8'h20);
    expect_reg("R3 day", 4'd5, 8'h15);
  endtask

  task automatic t_subsec;
    logic [7:0] v;
    wr(4'd15, 8'h0A);
    expect_reg("R4 cleared", 4'd0, 8'h00);
    run_for(128);  // about 130 running edges, 65 ticks
    rd(4'd0, v);
    n_run++;
    if (!(v >= 8'h40 && v <= 8'h42)) begin
      n_fail++;
      $display("FAIL R4 subsec actual=%h expected=41", v);
    end
    chk("R4 bit6", {7'd0, v[6]}, 8'h01);
    wr(4'd15, 8'h0A);
    expect_reg("R4 prescaler reset", 4'd0, 8'h00);
  endtask

  task automatic t_enable;
    wr(4'd15, 8'h0A);
    wr(4'd15, 8'h01);
    repeat (100) @(negedge clk);
    expect_reg("R11 no enable", 4'd0, 8'h00);
    wr(4'd15, 8'h0B);
    repeat (100) @(negedge clk);
    expect_reg("R11 reset held", 4'd0, 8'h00);
    expect_reg("R11 ctlb", 4'd15, 8'h0B);
  endtask

  task automatic t_roll(input string req, input logic [7:0] cent, yr, mon, day, wd,
                        input logic [7:0] e_cent, e_yr, e_mon, e_day, e_wd);
    load_time(cent, yr, mon, day, wd, 8'h23, 8'h59, 8'h59);
    run_for(300);
    expect_reg({req, " R5 sec"}, 4'd1, 8'h00);
    expect_reg({req, " R5 min"}, 4'd2, 8'h00);
    expect_reg({req, " R5 hour"}, 4'd3, 8'h00);
    expect_reg({req, " R6 wday"}, 4'd4, e_wd);
    expect_reg({req, " R7 day"}, 4'd5, e_day);
    expect_reg({req, " R8 mon"}, 4'd6, e_mon);
    expect_reg({req, " R8 year"}, 4'd7, e_yr);
    expect_reg({req, " R8 cent"}, 4'd8, e_cent);
  endtask

  task automatic t_mid_roll;
    load_time(8'h20, 8'h22, 8'h03, 8'h09, 8'h01, 8'h08, 8'h14, 8'h59);
    run_for(300);
    expect_reg("R5 sec only", 4'd1, 8'h00);
    expect_reg("R5 min carry", 4'd2, 8'h15);
    expect_reg("R5 hour hold", 4'd3, 8'h08);
  endtask

  task automatic t_carry;
    expect_reg("R9 flag set", 4'd14, 8'h80);
    chk("R10 irq off", {7'd0, irq}, 8'h00);
    wr(4'd14, 8'h90);
    expect_reg("R9 write one keeps", 4'd14, 8'h90);
    chk("R10 irq on", {7'd0, irq}, 8'h01);
    wr(4'd14, 8'h10);
    expect_reg("R9 write zero clears", 4'd14, 8'h10);
    chk("R10 irq cleared", {7'd0, irq}, 8'h00);
    wr(4'd14, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_load();
    t_run_write();
    t_subsec();
    t_enable();
    t_mid_roll();
    t_roll("feb28", 8'h20, 8'h23, 8'h02, 8'h28, 8'h06, 8'h20, 8'h23, 8'h03, 8'h01, 8'h00);
    t_roll("leap",  8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h20, 8'h24, 8'h02, 8'h29, 8'h03);
    t_roll("feb29", 8'h20, 8'h24, 8'h02, 8'h29, 8'h03, 8'h20, 8'h24, 8'h03, 8'h01, 8'h04);
    t_roll("apr30", 8'h20, 8'h25, 8'h04, 8'h30, 8'h04, 8'h20, 8'h25, 8'h05, 8'h01, 8'h05);
    t_roll("jan31", 8'h20, 8'h25, 8'h01, 8'h30, 8'h05, 8'h20, 8'h25, 8'h01, 8'h31, 8'h06);
    t_roll("cent",  8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h21, 8'h00, 8'h01, 8'h01, 8'h06);
    t_carry();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule